// File: doc/BRIEF.md
# Encoded Interrupt Level Decoder

This block turns a 4-bit encoded external interrupt level into per-source control strobes for a chain of interrupt sources. Level 0 means no request. Levels 1 to 15 run from the lowest priority to the highest. The level is inverted by an exclusive-OR with all ones to select one chain position. Level 15 therefore maps to source 0, and level 1 maps to source 14. With the default width the chain holds 15 sources, so level 0 maps to index 15, which lies outside the chain and selects nothing.

The surrounding source logic reports, for each source, whether it is currently asserted and whether its enable count is nonzero. When a new level takes effect, the decoder drives one-cycle strobes:
- an assert strobe to the selected source if that source is not yet asserted;
- an enable-increment strobe to the selected source if its enable count is zero;
- a deassert strobe to every other source that is still asserted.

Pending evaluation and vector lookup belong to the neighbouring logic.

A two-state sequencer controls when strobes are issued.
- State IDLE: no strobes. The transition IDLE->APPLY is taken when the registered level differs from the last applied level; on that transition the new level is latched as applied.
- State APPLY: strobes are driven for exactly one cycle. The transition APPLY->IDLE is always taken. A level change that arrives during APPLY is picked up from IDLE on the following cycle.

Top module: `irl_level_decoder`

## Requirements
- R1: The level input is registered. A level first sampled at clock edge N produces its strobes in the cycle that follows edge N+1. If a second change is sampled during that strobe cycle, its strobes appear two cycles after the first strobe cycle.
- R2: The selected chain index equals the level XOR 15, so level L acts on source (15 - L). Bit i of every strobe and status vector belongs to source i.
- R3: The selected source receives an assert strobe only when its asserted status bit is 0. At most one assert strobe is active in any cycle.
- R4: The selected source receives an enable-increment strobe only when its enabled status bit is 0, meaning its enable count is zero. No other source ever receives an enable-increment strobe.
- R5: Every non-selected source whose asserted status bit is 1 receives a deassert strobe. Sources whose asserted bit is 0 receive none. The selected source is never deasserted.
- R6: Level 0 selects no source. It drives deassert strobes to all asserted sources and no assert or enable-increment strobes.
- R7: Strobes last exactly one cycle. No strobe is produced while the registered level is unchanged, even if the status inputs change.
- R8: After reset all strobes are 0 and the applied level is 0. Status changes alone then produce no strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irl_level | input | LVL_W | Encoded interrupt level, 0 = none |
| src_asserted | input | NSRC | Per-source asserted status |
| src_enabled | input | NSRC | Per-source flag: enable count nonzero |
| assert_stb | output | NSRC | One-cycle assert strobe per source |
| deassert_stb | output | NSRC | One-cycle deassert strobe per source |
| enable_stb | output | NSRC | One-cycle enable-increment strobe per source |

## Verification
The bench builds the block with the default LVL_W of 4, which gives a 15-source chain. With that width the end indices 0 and 14 are reachable, and so is the off-chain index 15 that level 0 selects. The mix of already-asserted, disabled and unrelated sources exercises every strobe combination. A back-to-back level change tests the IDLE/APPLY re-entry timing, and a run of status-only changes shows that nothing fires without a level change.

// File: rtl/irl_pkg.sv
package irl_pkg;

    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,
        ST_APPLY = 1'b1
    } irl_state_e;

endpackage

// File: rtl/irl_level_capture.sv
module irl_level_capture #(
    parameter int LVL_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LVL_W-1:0] level_in,
    output logic [LVL_W-1:0] level_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            level_q <= '0;
        end else begin
            level_q <= level_in;
        end
    end

endmodule

// File: rtl/irl_apply_fsm.sv
module irl_apply_fsm
    import irl_pkg::*;
#(
    parameter int LVL_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LVL_W-1:0] level_q,
    output logic             apply,
    output logic [LVL_W-1:0] applied_level
);

    irl_state_e state_q, state_d;
    logic [LVL_W-1:0] applied_d;

    // next-state selection
    always_comb begin
        state_d   = state_q;
        applied_d = applied_level;
        unique case (state_q)
            ST_IDLE: begin
                if (level_q != applied_level) begin
                    state_d   = ST_APPLY;
                    applied_d = level_q;
                end
            end
            ST_APPLY: begin
                state_d = ST_IDLE;
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q       <= ST_IDLE;
            applied_level <= '0;
        end else begin
            state_q       <= state_d;
            applied_level <= applied_d;
        end
    end

    // outputs
    always_comb begin
        apply = 1'b0;
        unique case (state_q)
            ST_IDLE:  apply = 1'b0;
            ST_APPLY: apply = 1'b1;
            default:  apply = 1'b0;
        endcase
    end

endmodule

// File: rtl/irl_select_decode.sv
module irl_select_decode #(
    parameter int LVL_W = 4,
    parameter int NSRC  = 15
) (
    input  logic [LVL_W-1:0] level,
    output logic [NSRC-1:0]  sel
);

    localparam logic [LVL_W-1:0] INV_MASK = {LVL_W{1'b1}};

    logic [LVL_W-1:0] chain_idx;
    assign chain_idx = level ^ INV_MASK;

    for (genvar i = 0; i < NSRC; i++) begin : g_sel
        localparam logic [LVL_W-1:0] POS = LVL_W'(i);
        assign sel[i] = (chain_idx == POS);
    end

endmodule

// File: rtl/irl_strobe_gen.sv
module irl_strobe_gen #(
    parameter int NSRC = 15
) (
    input  logic            apply,
    input  logic [NSRC-1:0] sel,
    input  logic [NSRC-1:0] src_asserted,
    input  logic [NSRC-1:0] src_enabled,
    output logic [NSRC-1:0] assert_stb,
    output logic [NSRC-1:0] deassert_stb,
    output logic [NSRC-1:0] enable_stb
);

    for (genvar i = 0; i < NSRC; i++) begin : g_src
        assign assert_stb[i]   = apply &  sel[i] & ~src_asserted[i];
        assign enable_stb[i]   = apply &  sel[i] & ~src_enabled[i];
        assign deassert_stb[i] = apply & ~sel[i] &  src_asserted[i];
    end

endmodule

// File: rtl/irl_level_decoder.sv
module irl_level_decoder #(
    parameter  int LVL_W = 4,
    localparam int NSRC  = (1 << LVL_W) - 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LVL_W-1:0] irl_level,
    input  logic [NSRC-1:0]  src_asserted,
    input  logic [NSRC-1:0]  src_enabled,
    output logic [NSRC-1:0]  assert_stb,
    output logic [NSRC-1:0]  deassert_stb,
    output logic [NSRC-1:0]  enable_stb
);

    logic [LVL_W-1:0] level_q;
    logic [LVL_W-1:0] applied_level;
    logic             apply;
    logic [NSRC-1:0]  sel;

    irl_level_capture #(.LVL_W(LVL_W)) cap_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .level_in (irl_level),
        .level_q  (level_q)
    );

    irl_apply_fsm #(.LVL_W(LVL_W)) fsm_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .level_q       (level_q),
        .apply         (apply),
        .applied_level (applied_level)
    );

    irl_select_decode #(.LVL_W(LVL_W), .NSRC(NSRC)) dec_i (
        .level (applied_level),
        .sel   (sel)
    );

    irl_strobe_gen #(.NSRC(NSRC)) stb_i (
        .apply        (apply),
        .sel          (sel),
        .src_asserted (src_asserted),
        .src_enabled  (src_enabled),
        .assert_stb   (assert_stb),
        .deassert_stb (deassert_stb),
        .enable_stb   (enable_stb)
    );

endmodule

// File: rtl/irl_level_decoder_chk.sv
module irl_level_decoder_chk #(
    parameter int NSRC = 15
) (
    input logic            clk,
    input logic            rst_n,
    input logic [NSRC-1:0] src_asserted,
    input logic [NSRC-1:0] src_enabled,
    input logic [NSRC-1:0] assert_stb,
    input logic [NSRC-1:0] deassert_stb,
    input logic [NSRC-1:0] enable_stb
);

    logic any_stb;
    assign any_stb = |{assert_stb, deassert_stb, enable_stb};

    // R3
    assert_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(assert_stb));

    // R3
    assert_idle_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (assert_stb & src_asserted) == '0);

    // R4
    enable_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(enable_stb) && ((enable_stb & src_enabled) == '0));

    // R5
    deassert_live_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (deassert_stb & ~src_asserted) == '0);

    // R5
    no_conflict_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (deassert_stb & (assert_stb | enable_stb)) == '0);

    // R7
    single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        any_stb |=> !any_stb);

endmodule

bind irl_level_decoder irl_level_decoder_chk #(.NSRC(NSRC)) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .src_asserted (src_asserted),
    .src_enabled  (src_enabled),
    .assert_stb   (assert_stb),
    .deassert_stb (deassert_stb),
    .enable_stb   (enable_stb)
);

// File: tb/irl_level_decoder_tb_top.sv
`timescale 1ns/1ps
module irl_level_decoder_tb_top;

    localparam int LVL_W = 4;
    localparam int NSRC  = 15;

    typedef struct {
        int              due;
        logic [NSRC-1:0] a;
        logic [NSRC-1:0] d;
        logic [NSRC-1:0] e;
        string           tag;
    } exp_t;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [LVL_W-1:0] irl_level = '0;
    logic [NSRC-1:0]  src_asserted = '0;
    logic [NSRC-1:0]  src_enabled = '0;
    logic [NSRC-1:0]  assert_stb, deassert_stb, enable_stb;

    int   cyc = 0;
    int   checks = 0;
    int   errors = 0;
    bit   mon_on = 1'b0;
    logic [LVL_W-1:0] cur_lvl = '0;
    exp_t q[$];
    exp_t cur;

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    irl_level_decoder #(.LVL_W(LVL_W)) dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .irl_level    (irl_level),
        .src_asserted (src_asserted),
        .src_enabled  (src_enabled),
        .assert_stb   (assert_stb),
        .deassert_stb (deassert_stb),
        .enable_stb   (enable_stb)
    );

    function automatic exp_t make_exp(input logic [LVL_W-1:0] lvl,
                                      input logic [NSRC-1:0] asrt,
                                      input logic [NSRC-1:0] en,
                                      input int due, input string tag);
        exp_t x;
        logic [NSRC-1:0] s;
        int idx;
        idx = 15 - int'(lvl);
        s = '0;
        if (lvl != 0) s[idx] = 1'b1;
        x.due = due;
        x.a = s & ~asrt;
        x.e = s & ~en;
        x.d = ~s & asrt;
        x.tag = tag;
        return x;
    endfunction

    // driver: apply stimulus, push expected strobe item
    task automatic step(input logic [LVL_W-1:0] lvl, input logic [NSRC-1:0] asrt,
                        input logic [NSRC-1:0] en, input string tag);
        @(negedge clk);
        src_asserted = asrt;
        src_enabled  = en;
        irl_level    = lvl;
        if (lvl != cur_lvl) q.push_back(make_exp(lvl, asrt, en, cyc + 2, tag));
        cur_lvl = lvl;
        repeat (4) @(negedge clk);
    endtask

    // monitor: compare at each negedge
    always @(negedge clk) begin
        if (mon_on) begin
            checks++;
            if (q.size() > 0 && q[0].due == cyc) begin
                cur = q.pop_front();
                if (assert_stb !== cur.a || deassert_stb !== cur.d || enable_stb !== cur.e) begin
                    errors++;
                    $display("FAIL %s a=%h/%h d=%h/%h e=%h/%h", cur.tag,
                             assert_stb, cur.a, deassert_stb, cur.d, enable_stb, cur.e);
                end
            end else if ((assert_stb | deassert_stb | enable_stb) !== '0) begin
                errors++;
                $display("FAIL R7 quiet cycle a=%h d=%h e=%h expected 0",
                         assert_stb, deassert_stb, enable_stb);
            end
        end
    end

    initial begin
        #40000;
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        checks++;
        // R8 reset state
        if ((assert_stb | deassert_stb | enable_stb) !== '0) begin
            errors++;
            $display("FAIL R8 strobes after reset %h expected 0",
                     assert_stb | deassert_stb | enable_stb);
        end
        mon_on = 1'b1;
        // R8 status change alone after reset: no strobes
        step(4'd0, 15'h7FFF, 15'h0000, "R8");
        // R2 R3 R4 level 15 -> source 0, not asserted, disabled
        step(4'd15, 15'h0000, 15'h0000, "R2");
        // R5 level 1 -> source 14; source 0 deasserted, 14 enabled already
        step(4'd1, 15'h0001, 15'h4000, "R5");
        // R3 R4 level 8 -> source 7 already asserted but disabled; 2 and 9 deasserted
        step(4'd8, 15'h0284, 15'h7F7F, "R4");
        // R3 selected already asserted and enabled: only deasserts
        step(4'd3, 15'h1101, 15'h7FFF, "R3");
        // R7 same level, status changes: nothing
        step(4'd3, 15'h0FFF, 15'h0000, "R7");
        step(4'd3, 15'h0000, 15'h7FFF, "R7");
        // R6 level 0 deasserts all
        step(4'd0, 15'h7FFF, 15'h0000, "R6");
        // R6 level 0 with sparse assertion
        step(4'd14, 15'h0000, 15'h7FFF, "R2");
        step(4'd0, 15'h2A55, 15'h7FFF, "R6");
        // R1 back-to-back change
        @(negedge clk);
        src_asserted = 15'h0400;
        src_enabled  = 15'h0000;
        irl_level    = 4'd5;
        q.push_back(make_exp(4'd5, 15'h0400, 15'h0000, cyc + 2, "R1"));
        @(negedge clk);
        irl_level    = 4'd6;
        q.push_back(make_exp(4'd6, 15'h0400, 15'h0000, cyc + 3, "R1"));
        cur_lvl = 4'd6;
        repeat (6) @(negedge clk);
        // sweep all levels
        for (int l = 1; l < 16; l++) begin
            step(LVL_W'(l), 15'h5555, 15'h3333, "R2");
        end
        step(4'd0, 15'h5555, 15'h3333, "R6");
        repeat (3) @(negedge clk);
        if (q.size() != 0) begin
            errors++;
            $display("FAIL R1 %0d expected items not seen, expected 0", q.size());
        end
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule